// File: doc/BRIEF.md
# Configuration Manager Control Sequencer

This block sits on a 32-bit register bus and steers an external programmable device through its configuration phases. Software writes a control register to set the chip-enable, the configuration pull, the clock-to-data ratio and the data width. It then opens a transfer window and streams configuration words through a separate data-write port. A status register returns the tracked configuration phase, the five mode-select input pins and a sticky error flag.

The phase is tracked inside the block. It is derived from the power-good input, the pull control and the device status pins (done and active-low status). After the device reports a good configuration, the block counts a fixed number of post-configuration clocks before it declares user mode. Words written to the data port are forwarded for one cycle only while the transfer-enable bit is set. In 16-bit width mode the upper half of a forwarded word is zeroed. A word written while transfer is disabled is dropped and the error flag is raised.

Top module: `cfgseq_top`

## Requirements
- R1: After reset the control register reads zero, the phase reads power-up (0), `cfg_data_vld` is low and the error flag (status bit 8) is clear.
- R2: Reading the status register (address 0x0) returns the phase in bits [2:0], the `mode_sel` pins in bits [7:3] and the error flag in bit 8, with all other bits zero.
- R3: Writing the control register (address 0x4) stores only bits 0 (enable), 1 (active-low chip enable), 2 (config pull), 7:6 (ratio code), 8 (transfer enable) and 9 (wide). All other bits read back as zero. `cfg_en` follows bit 0, `dev_nce` follows bit 1 and `dev_ncfg` is the inverse of bit 2.
- R4: While `pwr_good` is low the phase becomes power-up (0) on the next clock. When power is good in power-up, the phase becomes unknown (5) on the next clock.
- R5: While powered with the config pull bit set, the phase becomes reset (1) on the next clock from any phase.
- R6: In reset with the pull bit clear, the phase becomes configuring (2) on the next clock.
- R7: In configuring, `dev_conf_done` and `dev_nstatus` both high move the phase to initialising (3). `dev_nstatus` low moves it to unknown (5). Any other pin state leaves it in configuring.
- R8: The phase stays in initialising for POST_CLKS cycles (4 by default) and then becomes user mode (4). User mode holds until pull or power loss.
- R9: A data-port write while transfer enable (bit 8) is set raises `cfg_data_vld` for the next cycle with the word on `cfg_data`. If the wide bit (bit 9) is clear, the upper 16 bits of `cfg_data` are zero.
- R10: A data-port write while transfer enable is clear is dropped: `cfg_data_vld` stays low and the error flag sets and stays set. Writing 1 to status bit 8 clears the flag.
- R11: `cfg_div` equals 1, 2, 4 or 8 for ratio codes 00, 01, 10 and 11. `cfg_wide` follows bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dat_wr | input | 1 | Configuration data write strobe |
| dat_wdata | input | 32 | Configuration data word |
| mode_sel | input | 5 | Mode-select pins |
| pwr_good | input | 1 | Device supply is up |
| dev_nstatus | input | 1 | Device status, active low |
| dev_conf_done | input | 1 | Device reports configuration done |
| cfg_en | output | 1 | Manager enable |
| dev_nce | output | 1 | Chip enable to device, active low |
| dev_ncfg | output | 1 | Configuration pull to device, active low |
| cfg_div | output | 4 | Clock-to-data ratio factor |
| cfg_wide | output | 1 | 32-bit data width selected |
| cfg_data_vld | output | 1 | Forwarded word valid |
| cfg_data | output | 32 | Forwarded configuration word |

## Verification
A wrong phase register shows up on status bits [2:0] one clock after the pin or control change that should have moved it. A post-clock counter that is off by one moves the user-mode transition by one cycle, and the bench catches that with a cycle-by-cycle read during initialising. A wrong gate decision shows on `cfg_data_vld` and on the error bit in the cycle right after the data write. A missing width mask shows on the upper half of `cfg_data` in that same cycle. The control field decode is swept over every ratio and width combination, and the status pins are swept over all 32 values.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    PH_PWRUP   = 3'd0,
    PH_RESET   = 3'd1,
    PH_CONFIG  = 3'd2,
    PH_INIT    = 3'd3,
    PH_USER    = 3'd4,
    PH_UNKNOWN = 3'd5
  } phase_e;

  localparam int CTRL_W     = 10;
  localparam int B_EN       = 0;
  localparam int B_NCE      = 1;
  localparam int B_PULL     = 2;
  localparam int B_DIV_LO   = 6;
  localparam int B_DIV_HI   = 7;
  localparam int B_XFER     = 8;
  localparam int B_WIDE     = 9;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 10'h3C7;
  localparam int B_ERR      = 8;

  // ratio code to clock factor
  function automatic logic [3:0] div_factor(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/cfgseq_regs.sv
module cfgseq_regs
  import cfgseq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  phase_e            phase,
  input  logic [SEL_W-1:0]  mode_sel,
  input  logic              err,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              err_clr
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4);
  localparam int STAT_USED = 3 + SEL_W + 1;

  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign err_clr = reg_wr && (reg_addr == A_STAT) && reg_wdata[B_ERR];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= reg_wdata[CTRL_W-1:0] & CTRL_MASK;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_STAT)
      reg_rdata[STAT_USED-1:0] = {err, mode_sel, phase};
    else if (reg_addr == A_CTRL)
      reg_rdata[CTRL_W-1:0] = ctrl_q;
  end

  // R3: unused control bits never become set
  p_ctrl_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_MASK) == '0);

endmodule

// File: rtl/cfgseq_phase.sv
module cfgseq_phase
  import cfgseq_pkg::*;
#(
  parameter int POST_CLKS = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_good,
  input  logic   pull,
  input  logic   dev_nstatus,
  input  logic   dev_conf_done,
  output phase_e phase_q
);
  localparam int CNT_W = $clog2(POST_CLKS + 1);

  phase_e            phase_d;
  logic [CNT_W-1:0]  cnt_q;
  logic              cfg_ok, cfg_fail, post_done;

  assign cfg_ok    = dev_conf_done && dev_nstatus;
  assign cfg_fail  = !dev_nstatus;
  assign post_done = (cnt_q == CNT_W'(POST_CLKS - 1));

  always_comb begin
    phase_d = phase_q;
    if (!pwr_good)  phase_d = PH_PWRUP;
    else if (pull)  phase_d = PH_RESET;
    else begin
      case (phase_q)
        PH_PWRUP:  phase_d = PH_UNKNOWN;
        PH_RESET:  phase_d = PH_CONFIG;
        PH_CONFIG: if (cfg_ok) phase_d = PH_INIT;
                   else if (cfg_fail) phase_d = PH_UNKNOWN;
        PH_INIT:   if (post_done) phase_d = PH_USER;
        default:   phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase_q <= PH_PWRUP;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= (phase_q == PH_INIT && !post_done) ? cnt_q + 1'b1 : '0;
    end

  p_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> phase_q == PH_PWRUP);
  p_pull_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && pull) |=> phase_q == PH_RESET);
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && !pull && phase_q == PH_RESET) |=> phase_q == PH_CONFIG);
  p_init_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_INIT && pwr_good && !pull) |=>
      (phase_q == PH_INIT || phase_q == PH_USER));

endmodule

// File: rtl/cfgseq_gate.sv
module cfgseq_gate #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              xfer_en,
  input  logic              wide,
  input  logic              err_clr,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              err_q
);
  localparam int HALF = DATA_W / 2;

  function automatic logic [DATA_W-1:0] fit_width(input logic w,
                                                  input logic [DATA_W-1:0] d);
    return w ? d : {{(DATA_W-HALF){1'b0}}, d[HALF-1:0]};
  endfunction

  logic accept, drop;
  assign accept = dat_wr && xfer_en;
  assign drop   = dat_wr && !xfer_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      err_q    <= 1'b0;
    end else begin
      out_vld <= accept;
      if (accept) out_data <= fit_width(wide, dat_wdata);
      if (drop)         err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end

  p_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_vld);
  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (!out_vld && err_q));
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);

endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
  import cfgseq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 5,
  parameter int POST_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic [SEL_W-1:0]  mode_sel,
  input  logic              pwr_good,
  input  logic              dev_nstatus,
  input  logic              dev_conf_done,
  output logic              cfg_en,
  output logic              dev_nce,
  output logic              dev_ncfg,
  output logic [3:0]        cfg_div,
  output logic              cfg_wide,
  output logic              cfg_data_vld,
  output logic [DATA_W-1:0] cfg_data
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              err_q, err_clr;
  phase_e            phase_q;

  cfgseq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .phase(phase_q), .mode_sel(mode_sel),
    .err(err_q), .reg_rdata(reg_rdata), .ctrl_q(ctrl_q), .err_clr(err_clr));

  cfgseq_phase #(.POST_CLKS(POST_CLKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pull(ctrl_q[B_PULL]),
    .dev_nstatus(dev_nstatus), .dev_conf_done(dev_conf_done),
    .phase_q(phase_q));

  cfgseq_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .xfer_en(ctrl_q[B_XFER]), .wide(ctrl_q[B_WIDE]), .err_clr(err_clr),
    .out_vld(cfg_data_vld), .out_data(cfg_data), .err_q(err_q));

  assign cfg_en   = ctrl_q[B_EN];
  assign dev_nce  = ctrl_q[B_NCE];
  assign dev_ncfg = !ctrl_q[B_PULL];
  assign cfg_div  = div_factor(ctrl_q[B_DIV_HI:B_DIV_LO]);
  assign cfg_wide = ctrl_q[B_WIDE];

  // R11: the divide factor is always a single power of two
  p_div_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cfg_div) == 1);

endmodule

// File: tb/cfgseq_top_tb.sv
`timescale 1ns/1ps
module cfgseq_top_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, dat_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, dat_wdata = '0, reg_rdata, cfg_data;
  logic [4:0]  mode_sel = '0;
  logic        pwr_good = 1'b0, dev_nstatus = 1'b1, dev_conf_done = 1'b0;
  logic        cfg_en, dev_nce, dev_ncfg, cfg_wide, cfg_data_vld;
  logic [3:0]  cfg_div;
  int n_chk = 0, n_bad = 0;

  cfgseq_top u_dut (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic dwr(input logic [31:0] d);
    dat_wr = 1'b1; dat_wdata = d;
    cyc();
    dat_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h4, v); check("R1 ctrl", v, 0);
    rd(4'h0, v); check("R1 phase", v[2:0], 0);
    check("R1 err", v[8], 0);
    check("R1 vld", cfg_data_vld, 0);
    // R2 mode-select sweep
    for (int m = 0; m < 32; m++) begin
      mode_sel = 5'(m);
      rd(4'h0, v);
      check("R2 status", v, 32'(m) << 3);
    end
    // R4 power good leaves power-up for unknown
    pwr_good = 1'b1; cyc();
    rd(4'h0, v); check("R4 unknown", v[2:0], 5);
    // R3 / R11 control sweep
    for (int r = 0; r < 4; r++)
      for (int w = 0; w < 2; w++) begin
        logic [31:0] val;
        val = 32'hFFFF_0038 | (32'(w) << 9) | (32'(r) << 6) | 32'h3;
        wr_reg(4'h4, val);
        rd(4'h4, v); check("R3 ctrl readback", v, val & 32'h3C7);
        check("R3 en", cfg_en, 1); check("R3 nce", dev_nce, 1);
        check("R3 ncfg", dev_ncfg, 1);
        check("R11 div", cfg_div, 32'd1 << r);
        check("R11 wide", cfg_wide, w);
      end
    // R5 pull -> reset
    wr_reg(4'h4, 32'h5);
    check("R3 ncfg low", dev_ncfg, 0);
    cyc(); rd(4'h0, v); check("R5 reset", v[2:0], 1);
    // R6 release -> configuring
    wr_reg(4'h4, 32'h1);
    cyc(); rd(4'h0, v); check("R6 config", v[2:0], 2);
    // R9 forwarding, 16-bit then 32-bit
    for (int w = 0; w < 2; w++) begin
      wr_reg(4'h4, 32'h101 | (32'(w) << 9));
      for (int i = 0; i < 8; i++) begin
        logic [31:0] d;
        d = 32'hA5C3_96E1 ^ (32'(i) * 32'h1357_9BDF);
        dwr(d);
        check("R9 vld", cfg_data_vld, 1);
        check("R9 data", cfg_data, w ? d : (d & 32'h0000_FFFF));
      end
      cyc(); check("R9 vld idle", cfg_data_vld, 0);
    end
    // R10 drop and sticky error
    wr_reg(4'h4, 32'h1);
    dwr(32'hDEAD_BEEF);
    check("R10 no vld", cfg_data_vld, 0);
    rd(4'h0, v); check("R10 err set", v[8], 1);
    cyc(); cyc();
    rd(4'h0, v); check("R10 err sticky", v[8], 1);
    wr_reg(4'h0, 32'h100);
    rd(4'h0, v); check("R10 err clear", v[8], 0);
    check("R7 still config", v[2:0], 2);
    // R7 / R8 good configuration
    dev_conf_done = 1'b1; cyc();
    rd(4'h0, v); check("R7 init", v[2:0], 3);
    for (int k = 1; k <= 4; k++) begin
      cyc(); rd(4'h0, v);
      check("R8 post clocks", v[2:0], (k < 4) ? 3 : 4);
    end
    cyc(); rd(4'h0, v); check("R8 user holds", v[2:0], 4);
    // R7 failure path
    dev_conf_done = 1'b0;
    wr_reg(4'h4, 32'h5); cyc();
    rd(4'h0, v); check("R5 reset from user", v[2:0], 1);
    wr_reg(4'h4, 32'h1); cyc();
    rd(4'h0, v); check("R6 config again", v[2:0], 2);
    dev_nstatus = 1'b0; cyc();
    rd(4'h0, v); check("R7 fail unknown", v[2:0], 5);
    // R4 power loss
    pwr_good = 1'b0; cyc();
    rd(4'h0, v); check("R4 powerup", v[2:0], 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule